// File: doc/BRIEF.md
# Instruction decode control generator

This block is the decode stage of a small 16-bit processor. On every rising clock edge where its enable is high, it latches the instruction word and forwards the incremented program counter from the fetch stage. From the 4-bit opcode and the immediate-mode bit it also produces two registered control fields. The first is a 6-bit execute-control word that steers the operand and address multiplexers of the execute stage. The second is a 2-bit writeback-select code that picks the source of the register-file write data.

While the enable is low the stage stalls, and every output keeps its value. A synchronous, active-high reset clears all outputs. Opcodes that carry no function here decode to all-zero control.

Top module: `instr_decode_ctl`

## Requirements
- R1: A rising edge with `rst` high sets `ir_q`, `pc_next_q`, `exec_ctl` and `wb_sel` to 0.
- R2: A rising edge with `rst` low and `dec_en` high loads `instr_in` into `ir_q` and `pc_next_in` into `pc_next_q`.
- R3: A rising edge with `rst` low and `dec_en` low leaves all four outputs unchanged, whatever the data inputs are.
- R4: `exec_ctl` is packed as follows:
  - `[5:4]` is the ALU operation: 0 = add, 1 = and, 2 = invert.
  - `[3:2]` is the address-offset select: 1 = 9-bit offset, 2 = 6-bit offset, 3 = zero.
  - `[1]` is the address-base select: 1 = next PC, 0 = first source register.
  - `[0]` is the second-operand select: 1 = second register, 0 = 5-bit immediate.
  - The field is computed from the instruction captured at that edge.
- R5: Opcode 0001 (add) gives ALU operation 0 and opcode 0101 (and) gives ALU operation 1. For both, instruction bit 5 = 0 gives operand select 1 and bit 5 = 1 gives operand select 0. Opcode 1001 (invert) gives `exec_ctl` = 6'b10_0000. The address fields are 0 for all three.
- R6: Opcodes 0000 (branch), 0010, 0011, 1010, 1011 and 1110 (address-of) give `exec_ctl` = 6'b00_0110.
- R7: Opcodes 0110 and 0111 (base-register load/store) give `exec_ctl` = 6'b00_1000. Opcode 1100 (jump) gives 6'b00_1100.
- R8: `wb_sel` is:
  - 0 (ALU result) for 0001, 0101 and 1001.
  - 1 (memory result) for 0010, 0110 and 1010.
  - 2 (address result) for 1110.
  - 0 for every other opcode.
  - It never takes the value 3.
- R9: Opcodes 0100, 1000, 1101 and 1111 give `exec_ctl` = 0 and `wb_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Stage enable; low stalls all outputs |
| instr_in | input | 16 | Instruction word from instruction memory |
| pc_next_in | input | 16 | Incremented PC from the fetch stage |
| ir_q | output | 16 | Captured instruction |
| pc_next_q | output | 16 | Forwarded incremented PC |
| exec_ctl | output | 6 | Execute-stage control word |
| wb_sel | output | 2 | Writeback data-source select |

## Verification
The assertions take `rst`, `dec_en` and the data inputs to be settled, known values at every rising edge. They also take reset to be applied at the first edge, because the reset property is the only one active before reset is released. The stimulus therefore holds reset through the first edges and changes inputs only on falling edges. It walks every opcode with both values of bit 5, and it toggles the enable from a pseudo-random sequence. Stall cycles deliberately present new instruction and PC values, so that holding can be observed at the outputs.

// File: rtl/instr_decode_ctl.sv
module instr_decode_ctl #(
  parameter int INSTR_W = 16,
  parameter int PC_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_en,
  input  logic [INSTR_W-1:0] instr_in,
  input  logic [PC_W-1:0]    pc_next_in,
  output logic [INSTR_W-1:0] ir_q,
  output logic [PC_W-1:0]    pc_next_q,
  output logic [5:0]         exec_ctl,
  output logic [1:0]         wb_sel
);
  localparam int OPC_LSB = INSTR_W - 4;
  localparam int IMM_BIT = 5;

  localparam logic [1:0] ALU_ADD = 2'd0, ALU_AND = 2'd1, ALU_INV = 2'd2;
  localparam logic [1:0] OFS_NONE = 2'd0, OFS_9 = 2'd1, OFS_6 = 2'd2, OFS_ZERO = 2'd3;
  localparam logic [1:0] WB_ALU = 2'd0, WB_MEM = 2'd1, WB_ADDR = 2'd2;

  logic [3:0] opc;
  logic       imm_mode;
  logic [1:0] alu_op, ofs_sel, wb_nx;
  logic       base_npc, op2_reg;

  assign opc      = instr_in[INSTR_W-1:OPC_LSB];
  assign imm_mode = instr_in[IMM_BIT];

  always_comb begin
    alu_op   = ALU_ADD;
    ofs_sel  = OFS_NONE;
    base_npc = 1'b0;
    op2_reg  = 1'b0;
    wb_nx    = WB_ALU;
    unique case (opc)
      4'b0001: op2_reg = ~imm_mode;
      4'b0101: begin alu_op = ALU_AND; op2_reg = ~imm_mode; end
      4'b1001: alu_op = ALU_INV;
      4'b0000, 4'b0011, 4'b1011: begin ofs_sel = OFS_9; base_npc = 1'b1; end
      4'b0010, 4'b1010: begin ofs_sel = OFS_9; base_npc = 1'b1; wb_nx = WB_MEM; end
      4'b1110: begin ofs_sel = OFS_9; base_npc = 1'b1; wb_nx = WB_ADDR; end
      4'b0110: begin ofs_sel = OFS_6; wb_nx = WB_MEM; end
      4'b0111: ofs_sel = OFS_6;
      4'b1100: ofs_sel = OFS_ZERO;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q      <= '0;
      pc_next_q <= '0;
      exec_ctl  <= '0;
      wb_sel    <= '0;
    end else if (dec_en) begin
      ir_q      <= instr_in;
      pc_next_q <= pc_next_in;
      exec_ctl  <= {alu_op, ofs_sel, base_npc, op2_reg};
      wb_sel    <= wb_nx;
    end
  end
endmodule

// File: rtl/instr_decode_ctl_chk.sv
module instr_decode_ctl_chk #(
  parameter int INSTR_W = 16,
  parameter int PC_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               dec_en,
  input logic [INSTR_W-1:0] instr_in,
  input logic [PC_W-1:0]    pc_next_in,
  input logic [INSTR_W-1:0] ir_q,
  input logic [PC_W-1:0]    pc_next_q,
  input logic [5:0]         exec_ctl,
  input logic [1:0]         wb_sel
);
  logic [3:0] opc;
  assign opc = instr_in[INSTR_W-1:INSTR_W-4];

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (ir_q == '0 && pc_next_q == '0 && exec_ctl == '0 && wb_sel == '0)); // R1
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst) dec_en |=> (ir_q == $past(instr_in) && pc_next_q == $past(pc_next_in))); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) !dec_en |=> ($stable(ir_q) && $stable(pc_next_q) && $stable(exec_ctl) && $stable(wb_sel))); // R3
  AST_ADD_OPERAND: assert property (@(posedge clk) disable iff (rst) (dec_en && opc == 4'b0001) |=> (exec_ctl[5:1] == 5'b0 && exec_ctl[0] == !$past(instr_in[5]))); // R5
  AST_PCREL_ADDR: assert property (@(posedge clk) disable iff (rst) (dec_en && (opc == 4'b0000 || opc == 4'b1110)) |=> exec_ctl == 6'b00_0110); // R6
  AST_JUMP_ADDR: assert property (@(posedge clk) disable iff (rst) (dec_en && opc == 4'b1100) |=> exec_ctl == 6'b00_1100); // R7
  AST_WB_NO_THREE: assert property (@(posedge clk) disable iff (rst) wb_sel != 2'd3); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) (dec_en && (opc == 4'b1000 || opc == 4'b1111)) |=> (exec_ctl == '0 && wb_sel == '0)); // R9
endmodule

bind instr_decode_ctl instr_decode_ctl_chk #(.INSTR_W(INSTR_W), .PC_W(PC_W)) chk_i (.*);

// File: tb/instr_decode_ctl_tb_top.sv
module instr_decode_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_en = 1'b0;
  logic [15:0] instr_in = '0, pc_next_in = '0;
  logic [15:0] ir_q, pc_next_q;
  logic [5:0]  exec_ctl;
  logic [1:0]  wb_sel;

  always #4 clk = ~clk;

  instr_decode_ctl dut_i (.clk(clk), .rst(rst), .dec_en(dec_en), .instr_in(instr_in),
    .pc_next_in(pc_next_in), .ir_q(ir_q), .pc_next_q(pc_next_q), .exec_ctl(exec_ctl), .wb_sel(wb_sel));

  int vectors = 0, errors = 0;

  // Reference: expected {exec, wb} and the requirement that governs the opcode class
  function automatic logic [7:0] model_ctl(input logic [15:0] w);
    int op = int'(w[15:12]);
    logic [1:0] alu = 0, ofs = 0, wb = 0;
    logic base = 0, sel2 = 0;
    if (op == 1 || op == 5) begin
      alu = (op == 5) ? 2'd1 : 2'd0;
      sel2 = (w[5] == 1'b0);
    end else if (op == 9) alu = 2'd2;
    else if (op inside {0, 2, 3, 10, 11, 14}) begin ofs = 2'd1; base = 1'b1; end
    else if (op == 6 || op == 7) ofs = 2'd2;
    else if (op == 12) ofs = 2'd3;
    if (op inside {2, 6, 10}) wb = 2'd1;
    if (op == 14) wb = 2'd2;
    return {alu, ofs, base, sel2, wb};
  endfunction

  function automatic string class_tag(input logic [15:0] w);
    int op = int'(w[15:12]);
    if (op inside {1, 5, 9}) return "R4,R5";
    if (op inside {0, 2, 3, 10, 11, 14}) return "R4,R6";
    if (op inside {6, 7, 12}) return "R4,R7";
    return "R4,R9";
  endfunction

  logic [15:0] m_ir = '0, m_npc = '0;
  logic [5:0]  m_ex = '0;
  logic [1:0]  m_wb = '0;
  string m_tag = "R1";
  string m_wtag = "R1";

  always @(posedge clk) begin
    logic [7:0] c;
    c = model_ctl(instr_in);
    if (rst) begin
      m_ir <= '0; m_npc <= '0; m_ex <= '0; m_wb <= '0; m_tag <= "R1"; m_wtag <= "R1";
    end else if (dec_en) begin
      m_ir <= instr_in; m_npc <= pc_next_in; m_ex <= c[7:2]; m_wb <= c[1:0];
      m_tag <= class_tag(instr_in); m_wtag <= "R8";
    end else begin
      m_tag <= "R3"; m_wtag <= "R3";
    end
  end

  always @(negedge clk) begin
    string dtag;
    dtag = (m_tag == "R3" || m_tag == "R1") ? m_tag : "R2";
    vectors++;
    if (ir_q !== m_ir || pc_next_q !== m_npc || exec_ctl !== m_ex || wb_sel !== m_wb) errors++;
    if (ir_q !== m_ir) $display("FAIL %s ir_q actual %h expected %h", dtag, ir_q, m_ir);
    if (pc_next_q !== m_npc) $display("FAIL %s pc_next_q actual %h expected %h", dtag, pc_next_q, m_npc);
    if (exec_ctl !== m_ex) $display("FAIL %s exec_ctl actual %b expected %b", m_tag, exec_ctl, m_ex);
    if (wb_sel !== m_wb) $display("FAIL %s wb_sel actual %0d expected %0d", m_wtag, wb_sel, m_wb);
  end

  task automatic step(input logic en, input logic [15:0] w, input logic [15:0] n);
    @(negedge clk);
    #1;
    dec_en = en; instr_in = w; pc_next_in = n;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    step(1'b1, 16'h1234, 16'h5678);   // R1: reset dominates enable
    step(1'b1, 16'h1234, 16'h5678);
    rst = 1'b0;
    step(1'b1, 16'h5020, 16'h3001);   // R5: and, immediate
    step(1'b1, 16'h1280, 16'h3002);   // R5: add, register
    step(1'b1, 16'hEDFE, 16'h3003);   // R6, R8: address-of
    step(1'b0, 16'h9FFF, 16'hFFFF);   // R3: stall with new data
    step(1'b0, 16'h0000, 16'h0000);
    for (int op = 0; op < 16; op++) begin
      for (int b5 = 0; b5 < 2; b5++) begin
        step(1'b1, {op[3:0], 6'b101010, b5[0], 5'b10101}, 16'h4000 + 16'(op * 2 + b5));
        step(1'b0, ~{op[3:0], 6'b101010, b5[0], 5'b10101}, 16'hBEEF);   // R3
      end
    end
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], lfsr ^ 16'h5A5A, {lfsr[7:0], lfsr[15:8]});
      if (i == 200) begin rst = 1'b1; step(1'b1, 16'hC1C1, 16'h2222); rst = 1'b0; end
    end
    step(1'b0, 16'h0, 16'h0);
    @(negedge clk);
    #2;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule